// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight edge-triggered interrupt requests, ranks them by a fixed priority, and tells a processor through one interrupt output that service is needed. The processor answers with a one-cycle acknowledge pulse. The controller then returns an eight-bit vector formed from a programmable base, moves the winning request into service, and holds back lower-priority requests until software ends that service with an end-of-interrupt command.

Software reaches the block through a two-address byte port. Address 0 is the command address and address 1 is the mask/data address. A command byte with bit 4 set starts a sequence of initialization words on the data address. The sequence loads the vector base, the set of inputs that carry a downstream controller, and a mode word that can turn on automatic end-of-interrupt. Outside that sequence, data writes set the mask. Command bytes choose which register a command-address read returns, or issue specific or non-specific end-of-interrupt commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, command-address reads return the request register, and `int_out` is low.
- R2: Outside initialization, a data-address write loads the mask and a data-address read returns it bit for bit. A mask bit of 1 stops that input from raising `int_out`, but its request bit is still recorded.
- R3: A command write with bit 4 set starts initialization. The next data write is the vector base. The following one sets the cascade-input bitmask, unless bit 1 of the start word (single mode) was set. Then comes a mode word, only if bit 0 of the start word was set. None of these writes changes the mask.
- R4: One cycle after an `inta` pulse, `vec_valid` is high for that cycle and `vec_out` equals the vector base plus the index of the serviced input.
- R5: Input 0 has the highest priority and input 7 the lowest. `int_out` is high only when an unmasked request is pending and no in-service bit of equal or higher priority is set.
- R6: An acknowledge clears the request bit of the highest-priority granted input and sets its in-service bit.
- R7: Command byte 0x0A selects the request register for command-address reads. Command byte 0x0B selects the in-service register.
- R8: Command byte 0x60+n (n in 0..7) clears in-service bit n and no other bit.
- R9: Command byte 0x20 clears the highest-priority in-service bit that is set.
- R10: When bit 1 of the mode word is set, an acknowledge leaves the in-service register unchanged. A new start word clears this mode.
- R11: An acknowledge while no request is granted returns base+7 and changes no in-service bit. This holds even when input 7 is masked or its request has already gone away.
- R12: A request is latched only on a rising edge and is dropped if the line falls before acknowledge. An input held high after acknowledge does not request again until it falls and rises.
- R13: `ack_cascade` is high together with `vec_valid` exactly when the serviced input is set in the cascade-input bitmask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = mask/data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |
| ack_cascade | output | 1 | Serviced input is marked as a cascade line |

## Verification
Every cycle, the assertions check the rules that tie state across a single edge. A granted acknowledge must leave an in-service bit set. Automatic end-of-interrupt and spurious acknowledges must leave the in-service register alone. A specific end-of-interrupt must clear its bit. Initialization words must not touch the mask. `int_out` must never rise without an unmasked request. Other behaviour needs full scenarios driven by the bench: the exact vector values, how nested priorities and blocking play out, non-specific end-of-interrupt ordering, the edge-only re-request rule, the readback selection, and the changes of sequence that single mode and the missing mode word cause.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic       ack_cascade
);

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_MODE} init_st_t;

  init_st_t   st_q;
  logic [7:0] imr_q, irr_q, isr_q, prev_q, base_q, casc_q;
  logic       aeoi_q, need_mode_q, single_q, rd_isr_q;
  logic [7:0] vec_q;
  logic       vec_valid_q, casc_hit_q;

  function automatic logic [2:0] top_index(input logic [7:0] v);
    logic [2:0] r;
    r = 3'd7;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = 3'(i);
    return r;
  endfunction

  logic [7:0] pend;
  logic [2:0] win;
  logic [8:0] upto;
  logic       grant;
  logic       cmd_wr, dat_wr, icw1_wr, ocw2_wr, ocw3_wr;
  logic [7:0] eoi_clr, ack_bit, irr_d, isr_d;
  logic       ack;

  assign pend    = irr_q & ~imr_q;
  assign win     = top_index(pend);
  assign upto    = (9'd2 << win) - 9'd1;
  assign grant   = (|pend) && !(|(isr_q & upto[7:0]));
  assign int_out = grant;

  assign cmd_wr  = wr_en && !addr;
  assign dat_wr  = wr_en && addr;
  assign icw1_wr = cmd_wr && wdata[4];
  assign ocw3_wr = cmd_wr && !wdata[4] && wdata[3];
  assign ocw2_wr = cmd_wr && !wdata[4] && !wdata[3];

  always_comb begin
    eoi_clr = 8'h00;
    if (ocw2_wr && wdata[7:5] == 3'b011) eoi_clr = 8'd1 << wdata[2:0];
    else if (ocw2_wr && wdata[7:5] == 3'b001) eoi_clr = isr_q & (~isr_q + 8'd1);
  end

  assign ack     = inta && grant;
  assign ack_bit = ack ? (8'd1 << win) : 8'h00;
  assign irr_d   = (irr_q | (irq_in & ~prev_q)) & irq_in & ~ack_bit;
  assign isr_d   = icw1_wr ? 8'h00 : ((isr_q & ~eoi_clr) | (aeoi_q ? 8'h00 : ack_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      imr_q       <= 8'hFF;
      irr_q       <= 8'h00;
      isr_q       <= 8'h00;
      prev_q      <= 8'h00;
      base_q      <= 8'h00;
      casc_q      <= 8'h00;
      aeoi_q      <= 1'b0;
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
      rd_isr_q    <= 1'b0;
      vec_q       <= 8'h00;
      vec_valid_q <= 1'b0;
      casc_hit_q  <= 1'b0;
    end else begin
      prev_q      <= irq_in;
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      vec_valid_q <= inta;
      if (inta) begin
        vec_q      <= base_q + (ack ? {5'd0, win} : 8'd7);
        casc_hit_q <= ack && casc_q[win];
      end
      if (ocw3_wr && wdata[1]) rd_isr_q <= wdata[0];
      if (icw1_wr) begin
        st_q        <= ST_BASE;
        need_mode_q <= wdata[0];
        single_q    <= wdata[1];
        aeoi_q      <= 1'b0;
        rd_isr_q    <= 1'b0;
        casc_q      <= 8'h00;
      end else if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin
            base_q <= wdata;
            st_q   <= !single_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_IDLE);
          end
          ST_CASC: begin
            casc_q <= wdata;
            st_q   <= need_mode_q ? ST_MODE : ST_IDLE;
          end
          ST_MODE: begin
            aeoi_q <= wdata[1];
            st_q   <= ST_IDLE;
          end
          default: imr_q <= wdata;
        endcase
      end
    end
  end

  assign rdata       = addr ? imr_q : (rd_isr_q ? isr_q : irr_q);
  assign vec_valid   = vec_valid_q;
  assign vec_out     = vec_q;
  assign ack_cascade = vec_valid_q && casc_hit_q;

  assert_int_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q & ~imr_q) != 8'h00);

  assert_ack_enters_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi_q && !wr_en) |=> isr_q != 8'h00);

  assert_spurious_keeps_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !wr_en) |=> isr_q == $past(isr_q));

  assert_auto_eoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi_q && !wr_en) |=> isr_q == $past(isr_q));

  assert_specific_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:5] == 3'b011 && !wdata[4] && !wdata[3] && !inta)
    |=> !isr_q[$past(wdata[2:0])]);

  assert_init_keeps_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && st_q != ST_IDLE) |=> $stable(imr_q));

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       inta = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic       ack_cascade;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_valid(vec_valid), .vec_out(vec_out), .ack_cascade(ack_cascade));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic acknowledge(input string tag, input logic [7:0] exp_vec, input logic exp_casc);
    inta = 1'b1;
    tick();
    chk(tag, {7'd0, vec_valid}, 8'h01);
    chk(tag, vec_out, exp_vec);
    chk("R13", {7'd0, ack_cascade}, {7'd0, exp_casc});
    inta = 1'b0;
    tick();
    chk(tag, {7'd0, vec_valid}, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    rd(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
    chk("R1 int", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R1 isr", d, 8'h00);
    wr(1'b0, 8'h0A);

    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R3 mask untouched", d, 8'hFF);

    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v)); rd(1'b1, d); chk("R2 mask readback", d, 8'(v));
    end
    wr(1'b1, 8'h00);

    for (int n = 0; n < 8; n++) begin
      irq_in[n] = 1'b1; tick();
      chk("R5 raise", {7'd0, int_out}, 8'h01);
      rd(1'b0, d); chk("R7 irr", d, 8'd1 << n);
      acknowledge("R4", 8'h40 + 8'(n), n == 2);
      wr(1'b0, 8'h0B); rd(1'b0, d); chk("R6 isr", d, 8'd1 << n);
      chk("R12 no rerequest", {7'd0, int_out}, 8'h00);
      wr(1'b0, 8'h60 + 8'(n)); rd(1'b0, d); chk("R8 specific eoi", d, 8'h00);
      wr(1'b0, 8'h0A); rd(1'b0, d); chk("R12 irr held line", d, 8'h00);
      irq_in[n] = 1'b0; tick();
    end

    wr(1'b0, 8'h0B);
    irq_in = 8'h28; tick();
    acknowledge("R5 pick 3", 8'h43, 1'b0);
    chk("R5 blocked by isr", {7'd0, int_out}, 8'h00);
    irq_in[1] = 1'b1; tick();
    chk("R5 higher preempts", {7'd0, int_out}, 8'h01);
    acknowledge("R5 pick 1", 8'h41, 1'b0);
    rd(1'b0, d); chk("R6 nested isr", d, 8'h0A);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R9 nonspecific eoi", d, 8'h08);
    chk("R5 still blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R9 second eoi", d, 8'h00);
    chk("R5 unblocked", {7'd0, int_out}, 8'h01);
    acknowledge("R4 pick 5", 8'h45, 1'b0);
    wr(1'b0, 8'h65); rd(1'b0, d); chk("R8 eoi 5", d, 8'h00);
    irq_in = 8'h00; tick();

    wr(1'b1, 8'h08); wr(1'b0, 8'h0A);
    irq_in[3] = 1'b1; tick();
    chk("R2 masked no int", {7'd0, int_out}, 8'h00);
    rd(1'b0, d); chk("R2 masked recorded", d, 8'h08);
    irq_in[3] = 1'b0; tick();
    wr(1'b1, 8'h00);

    irq_in[4] = 1'b1; tick();
    chk("R12 edge seen", {7'd0, int_out}, 8'h01);
    irq_in[4] = 1'b0; tick();
    chk("R12 dropped", {7'd0, int_out}, 8'h00);
    acknowledge("R11 spurious", 8'h47, 1'b0);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R11 isr clean", d, 8'h00);
    wr(1'b1, 8'hFF);
    acknowledge("R11 spurious masked", 8'h47, 1'b0);
    rd(1'b0, d); chk("R11 isr clean masked", d, 8'h00);
    wr(1'b1, 8'h00);

    wr(1'b0, 8'h13); wr(1'b1, 8'h80); wr(1'b1, 8'h02);
    rd(1'b1, d); chk("R3 single mode mask", d, 8'h00);
    irq_in[6] = 1'b1; tick();
    acknowledge("R10 vector", 8'h86, 1'b0);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R10 auto eoi isr", d, 8'h00);
    irq_in[6] = 1'b0; tick();

    wr(1'b0, 8'h12); wr(1'b1, 8'h90); wr(1'b1, 8'h5A);
    rd(1'b1, d); chk("R3 no mode word", d, 8'h5A);
    irq_in[0] = 1'b1; tick();
    acknowledge("R3 new base", 8'h90, 1'b0);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R10 cleared by start", d, 8'h01);
    wr(1'b0, 8'h60); rd(1'b0, d); chk("R8 eoi 0", d, 8'h00);
    irq_in[0] = 1'b0; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule